// File: doc/BRIEF.md
# Asynchronous static RAM port controller

This block connects a clocked host to an external asynchronous static RAM of 262,144 sixteen-bit words. The RAM has active-low strobes: chip select, write strobe, read (output) enable, and one enable for each byte lane. The host makes one request at a time. It raises `req` for a cycle while `busy` is low and gives a direction flag, an 18-bit word address, write data and a two-bit lane mask. The controller then runs a complete RAM cycle on the pins. Every interval that the RAM needs is counted in whole clock cycles, using a ceiling computed from nanosecond parameters and the clock period.

Writes are controlled by the write strobe. The address and all strobes are put in place first, with every strobe still inactive. The write strobe is then held low for at least the minimum pulse width, while read enable stays inactive throughout. The controller keeps driving the data bus for one recovery cycle after the strobe rises.

Reads hold read enable low for the worst-case access time plus one margin cycle. At the end of that window the controller registers the lanes that were enabled and raises `rd_valid` for a single clock. After a read, the controller does not turn on its own bus drivers until the RAM has had its release time to let go of the bus.

Top module: `asram_ctrl`

## Requirements
- R1: A write request stores `req_wdata` at word `req_addr`, and a later full-mask read of that word returns the same value. This holds for the lowest and the highest address.
- R2: After reset, and whenever `busy` is low, chip select, write strobe, read enable and both lane enables are high, and `mem_d_en` is low.
- R3: During a write, the write strobe stays low for exactly WP_CYC consecutive cycles (3 at the defaults). `mem_d_en` is high on every one of those cycles.
- R4: `mem_addr` changes only on a clock edge where all five strobes are high both before and after the edge.
- R5: Read enable stays high for the whole of every write. The write strobe stays high for the whole of every read.
- R6: `mem_d_en` never rises while read enable is low, nor in the HZ_CYC cycles (1 at the defaults) that follow read enable going high.
- R7: A request is taken only on an edge where `busy` is low, and `busy` is high on the next cycle. A request made while `busy` is high has no effect on the memory.
- R8: A read raises `rd_valid` for exactly one cycle, with `rd_data` holding the word that was on the bus when the read window closed. Lanes not enabled by the mask read as zero.
- R9: `req_mask` bit 0 enables bits 7..0 through `mem_lo_n`, and bit 1 enables bits 15..8 through `mem_hi_n`. A write changes only the enabled lanes. A write with mask 00 changes nothing.
- R10: With the default parameters, every request keeps `busy` high for exactly 5 cycles. For a read, `rd_valid` is high on the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, taken when busy is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| busy | output | 1 | Request in progress |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_rd_n | output | 1 | RAM output enable, active low |
| mem_lo_n | output | 1 | Low byte lane enable, active low |
| mem_hi_n | output | 1 | High byte lane enable, active low |
| mem_d_out | output | 16 | Data to drive onto the RAM bus |
| mem_d_in | input | 16 | Data sampled from the RAM bus |
| mem_d_en | output | 1 | Enable for the controller's bus drivers |

## Verification
The bench holds a RAM model that returns data only after three cycles of read enable, returns a junk pattern on disabled lanes, and watches the bus for contention.

Full-mask writes at the lowest and highest address show that data and addressing work at all. Single-lane writes, and a write with mask 00, over a known word show whether lane gating is correct or leaks across lanes. Reads with each mask value show whether the junk on disabled lanes is cleared to zero. A write issued right after a read shows whether the bus-release gap is respected. A second request held high during a busy write shows whether requests are taken only when ready. A run of mixed addresses and data checks that no state carries over from one request to the next.

// File: rtl/asram_pkg.sv
// Shared types and cycle arithmetic for the asynchronous RAM controller.
// Assumes all time parameters are integers in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WPULSE,
        PH_WREC,
        PH_RACC
    } phase_e;

    // Ceiling of ns / period, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Loadable down-counter used to time one phase. It stops at zero.
// Assumes load_val fits in CNT_W bits.
module asram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
// Phase sequencer. It steps IDLE -> SETUP, then either WPULSE -> WREC or RACC,
// and then back to IDLE. A write pulse waits in SETUP until the bus
// release gap that follows the last read has passed.
// Assumes start is asserted only while ready is high.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned WP_CYC = 3,
    parameter int unsigned RD_CYC = 4,
    parameter int unsigned HZ_CYC = 1,
    parameter int unsigned CNT_W  = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   capture,
    output logic   ready
);
    logic             is_wr;
    logic             ph_zero;
    logic             turn_zero;
    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic             turn_load;

    asram_phase_timer #(.CNT_W(CNT_W)) u_ph_tmr (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    asram_phase_timer #(.CNT_W(CNT_W)) u_turn_tmr (
        .clk(clk), .rst_n(rst_n), .load(turn_load),
        .load_val(CNT_W'(HZ_CYC)), .zero(turn_zero)
    );

    // Next-phase decode and phase timer loading.
    always_comb begin
        phase_d = phase_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (phase_q)
            PH_IDLE:   if (start) phase_d = PH_SETUP;
            PH_SETUP: begin
                if (!is_wr) begin
                    phase_d = PH_RACC;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(RD_CYC - 1);
                end else if (turn_zero) begin
                    phase_d = PH_WPULSE;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(WP_CYC - 1);
                end
            end
            PH_WPULSE: if (ph_zero) phase_d = PH_WREC;
            PH_WREC:   phase_d = PH_IDLE;
            PH_RACC:   if (ph_zero) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    assign capture   = (phase_q == PH_RACC) && ph_zero;
    assign turn_load = capture;
    assign ready     = (phase_q == PH_IDLE);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Remember the direction of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_wr <= 1'b0;
        else if (start)
            is_wr <= start_wr;
    end
endmodule

// File: rtl/asram_pins.sv
// Pin stage. It registers the address, strobes, write data and bus enable
// from the next phase, so each pin changes only on a clock edge. It also
// captures read data per lane. Assumes DATA_W = 8 * LANES.
module asram_pins
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  phase_e            phase_d,
    input  logic              capture,
    input  logic [DATA_W-1:0] d_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] d_out,
    output logic              d_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [LANES-1:0] mask_q;
    logic             active_d;

    assign active_d = (phase_d == PH_WPULSE) || (phase_d == PH_RACC);

    // Latch the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            d_out    <= '0;
            mask_q   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            d_out    <= req_wdata;
            mask_q   <= req_mask;
        end
    end

    // Shared strobes and bus enable, registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            wr_n <= 1'b1;
            rd_n <= 1'b1;
            d_en <= 1'b0;
        end else begin
            cs_n <= !active_d;
            wr_n <= (phase_d != PH_WPULSE);
            rd_n <= (phase_d != PH_RACC);
            d_en <= (phase_d == PH_WPULSE) || (phase_d == PH_WREC);
        end
    end

    // Read valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= capture;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane enable follows the mask only inside an active phase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_n[i] <= 1'b1;
            else
                lane_n[i] <= !(active_d && mask_q[i]);
        end

        // Capture one lane, clearing it when the lane was not enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[8*i +: 8] <= '0;
            else if (capture)
                rd_data[8*i +: 8] <= mask_q[i] ? d_in[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous RAM controller. It takes one host request at a
// time and turns it into a strobe-controlled RAM read or write. Every
// interval is a whole number of clock cycles derived from ns parameters.
// Assumes the host holds req only while it wants a transfer, and that it
// checks busy.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_WPULSE_NS   = 45,
    parameter int unsigned T_DSETUP_NS   = 25,
    parameter int unsigned T_WCYCLE_NS   = 55,
    parameter int unsigned T_RCYCLE_NS   = 55,
    parameter int unsigned T_ADDR_ACC_NS = 55,
    parameter int unsigned T_OE_ACC_NS   = 30,
    parameter int unsigned T_RELEASE_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              busy,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [15:0]       mem_d_out,
    input  logic [15:0]       mem_d_in,
    output logic              mem_d_en
);
    localparam int unsigned LANES  = 2;
    // The setup phase already gives one cycle of the write cycle time.
    localparam int unsigned WP_CYC = max2(max2(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS)),
                                          ns_to_cyc(T_WCYCLE_NS, CLK_PERIOD_NS) - 1);
    // Worst-case access time plus one margin cycle for capture.
    localparam int unsigned RD_CYC = max2(max2(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS)),
                                          ns_to_cyc(T_RCYCLE_NS, CLK_PERIOD_NS)) + 1;
    localparam int unsigned HZ_CYC = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned CNT_W  = $clog2(max2(max2(WP_CYC, RD_CYC), HZ_CYC) + 1);

    phase_e           phase_q;
    phase_e           phase_d;
    logic             capture;
    logic             ready;
    logic             accept;
    logic [LANES-1:0] lane_n;

    assign accept = req && ready;
    assign busy   = !ready;

    asram_seq #(
        .WP_CYC(WP_CYC), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_wr),
        .phase_q(phase_q), .phase_d(phase_d), .capture(capture), .ready(ready)
    );

    asram_pins #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .phase_d(phase_d), .capture(capture), .d_in(mem_d_in),
        .mem_addr(mem_addr), .cs_n(mem_cs_n), .wr_n(mem_wr_n), .rd_n(mem_rd_n),
        .lane_n(lane_n), .d_out(mem_d_out), .d_en(mem_d_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign mem_lo_n = lane_n[0];
    assign mem_hi_n = lane_n[1];
endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for asram_ctrl. It is bound to the top and watches only
// ports. Assumes WP_CYC matches the controller's write pulse length.
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned WP_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_lo_n,
    input logic              mem_hi_n,
    input logic              mem_d_en
);
    logic [7:0] wlow_cnt;
    logic       all_off;

    assign all_off = mem_cs_n && mem_wr_n && mem_rd_n && mem_lo_n && mem_hi_n;

    // Count consecutive cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wlow_cnt <= '0;
        else if (!mem_wr_n)
            wlow_cnt <= (wlow_cnt == 8'hFF) ? wlow_cnt : wlow_cnt + 1'b1;
        else
            wlow_cnt <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (all_off && !mem_d_en)); // R2
    AST_WPULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wlow_cnt == 8'(WP_CYC))); // R3
    AST_WPULSE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_d_en); // R3
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |-> (all_off && $past(all_off))); // R4
    AST_NO_RD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_rd_n); // R5
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_en |-> (mem_rd_n && $past(mem_rd_n))); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
    .mem_rd_n(mem_rd_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
    .mem_d_en(mem_d_en)
);

// File: tb/sim_asram_ctrl.sv
// Scoreboard bench for asram_ctrl with a cycle-level RAM model.
module sim_asram_ctrl;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          busy;
    logic [15:0]   rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n;
    logic [15:0]   mem_d_out;
    logic [15:0]   mem_d_in;
    logic          mem_d_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] mem    [int];
    logic [15:0] shadow [int];
    logic [15:0] exp_q  [$];

    always #10 clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .busy(busy), .rd_data(rd_data),
        .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_lo_n(mem_lo_n),
        .mem_hi_n(mem_hi_n), .mem_d_out(mem_d_out), .mem_d_in(mem_d_in),
        .mem_d_en(mem_d_en)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [15:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // RAM model: data appears after three cycles of read enable; disabled lanes carry junk.
    int rd_cnt = 0;
    int hz_left = 0;
    int wlow = 0;
    logic [AW-1:0] last_addr = '0;
    logic last_off = 1'b1;
    logic reading;
    assign reading = !mem_cs_n && !mem_rd_n && mem_wr_n;

    always_comb begin
        if (reading && rd_cnt >= 3)
            mem_d_in = {mem_hi_n ? 8'hEE : mem_rd(int'(mem_addr))[15:8],
                        mem_lo_n ? 8'hEE : mem_rd(int'(mem_addr))[7:0]};
        else
            mem_d_in = 16'hBAD0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            logic [15:0] w;
            logic off;
            off = mem_cs_n && mem_wr_n && mem_rd_n && mem_lo_n && mem_hi_n;
            if (!mem_cs_n && !mem_wr_n) begin
                w = mem_rd(int'(mem_addr));
                if (!mem_lo_n) w[7:0] = mem_d_out[7:0];
                if (!mem_hi_n) w[15:8] = mem_d_out[15:8];
                mem[int'(mem_addr)] = w;
                check(mem_d_en == 1'b1, "R3 data driven in pulse", 32'(mem_d_en), 32'd1);
            end
            if (!mem_wr_n) begin
                check(mem_rd_n == 1'b1, "R5 read enable in write", 32'(mem_rd_n), 32'd1);
                wlow <= wlow + 1;
            end else begin
                if (wlow != 0) check(wlow == 3, "R3 pulse width", 32'(wlow), 32'd3);
                wlow <= 0;
            end
            if (!mem_rd_n) check(mem_wr_n == 1'b1, "R5 write strobe in read", 32'(mem_wr_n), 32'd1);
            if (mem_addr != last_addr)
                check(off && last_off, "R4 strobes during address change", 32'(mem_addr), 32'(last_addr));
            if (mem_d_en)
                check(!reading && mem_rd_n && hz_left == 0, "R6 bus contention", 32'(hz_left), 32'd0);
            rd_cnt    <= reading ? rd_cnt + 1 : 0;
            hz_left   <= !mem_rd_n ? 1 : (hz_left > 0 ? hz_left - 1 : 0);
            last_addr <= mem_addr;
            last_off  <= off;
        end
    end

    // Monitor: pop and compare each read result.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0)
                check(1'b0, "R8 unexpected rd_valid", 32'(rd_data), 32'd0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R1 R8 R9 read data", 32'(rd_data), 32'(e));
            end
        end
    end

    // Driver: issue one request and wait for completion.
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
        int lat;
        while (busy) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        if (wr)
            shadow[int'(a)] = (shadow_rd(int'(a)) & ~lanes(m)) | (d & lanes(m));
        else
            exp_q.push_back(shadow_rd(int'(a)) & lanes(m));
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        lat = 0;
        while (busy) begin
            lat++;
            @(negedge clk);
        end
        check(lat == 5, "R10 busy cycles", 32'(lat), 32'd5);
        if (!wr) check(rd_valid == 1'b1, "R10 rd_valid as busy falls", 32'(rd_valid), 32'd1);
    endtask

    task automatic idle_check();
        check(!busy && mem_cs_n && mem_wr_n && mem_rd_n && mem_lo_n && mem_hi_n && !mem_d_en,
              "R2 idle pins", {26'd0, busy, mem_cs_n, mem_wr_n, mem_rd_n, mem_lo_n, mem_hi_n}, 32'h1F);
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R8 reads outstanding", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            check(1'b0, "watchdog expired", 32'(cycles), 32'd50000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check(); // R2 reset state
        check(rd_valid == 1'b0, "R2 rd_valid at reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 full words at both address extremes
        issue(1'b1, 18'h00000, 16'hA5C3, 2'b11);
        issue(1'b0, 18'h00000, 16'h0000, 2'b11);
        issue(1'b1, 18'h3FFFF, 16'h1234, 2'b11);
        issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        issue(1'b0, 18'h00000, 16'h0000, 2'b11);
        idle_check();

        // R9 single-lane and empty-mask writes
        issue(1'b1, 18'h00000, 16'hFF77, 2'b01);
        issue(1'b0, 18'h00000, 16'h0000, 2'b11);
        issue(1'b1, 18'h00000, 16'h9900, 2'b10);
        issue(1'b0, 18'h00000, 16'h0000, 2'b11);
        issue(1'b1, 18'h00000, 16'h0000, 2'b00);
        issue(1'b0, 18'h00000, 16'h0000, 2'b11);

        // R8 lane-masked reads return zero on disabled lanes
        issue(1'b0, 18'h00000, 16'h0000, 2'b01);
        issue(1'b0, 18'h00000, 16'h0000, 2'b10);
        issue(1'b0, 18'h00000, 16'h0000, 2'b00);

        // R6 write right after a read
        issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        issue(1'b1, 18'h00100, 16'h5A5A, 2'b11);
        issue(1'b0, 18'h00100, 16'h0000, 2'b11);

        // R7 request held during busy is ignored
        while (busy) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 18'h00200; req_wdata = 16'h1111; req_mask = 2'b11;
        shadow[32'h200] = 16'h1111;
        @(negedge clk);
        req_addr = 18'h00300; req_wdata = 16'h2222;
        repeat (3) @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        issue(1'b0, 18'h00300, 16'h0000, 2'b11);
        issue(1'b0, 18'h00200, 16'h0000, 2'b11);

        // R1 mixed addresses and data
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            a = AW'((i * 7919 + 13) % 262144);
            issue(1'b1, a, 16'(i * 16'h1357 + 16'h0F0F), 2'b11);
        end
        for (int i = 0; i < 8; i++)
            issue(1'b0, AW'((i * 7919 + 13) % 262144), 16'h0000, 2'b11);

        repeat (3) @(negedge clk);
        idle_check();
        finish_run();
    end
endmodule